// File: doc/BRIEF.md
# I2C Slave Address-Match Status Tracker

This block follows decoded bus events on the target side of an I2C link and keeps a 16-bit status word up to date. A bit-level front end, which is not part of this block, sends it single-cycle pulses for start, repeated start and stop. It also supplies the received address byte with a valid strobe, the second byte of a general call with its own strobe, and an acknowledge-slot strobe together with the transmit queue's empty flag. Software sees the status word through a read port. A read strobe clears the stop-done flag.

The block compares the upper seven bits of each address byte against four programmable target IDs and reports the index of the lowest ID that matched. The start byte (0x01) and the general-call address (0x00) are handled separately from the ID compare. After an accepted general call, the second byte is classified into a two-bit code. This code and the general-call-seen flag are sticky: they survive a general-call reset and clear only on a write-one clear strobe. The block also tracks repeated starts, busy state and NACK state. It raises a level interrupt when a stop closes an addressed transfer and the stop interrupt is enabled.

Top module: `i2cs_status_trk`

## Requirements
- R1: After reset `rd_data_o` reads 0x0000, `irq_o` is low, and bit 15 reads zero at all times.
- R2: On `addr_vld_i`, if `addr_byte_i[7:1]` is non-zero and equals one or more of the IDs in `cfg_ids_i` (ID k in bits [7k+6:7k]), bit 14 sets and bits 12:11 take the lowest matching index.
- R3: An address byte of 0x01 sets bit 14. An address byte of 0x00 sets bit 14 only while `cfg_gc_en_i` is high; otherwise it counts as a miss. Neither byte changes bits 12:11.
- R4: An address byte that is accepted by none of R2/R3 clears bit 6 and leaves bit 14 and bits 12:11 unchanged.
- R5: A start sets bit 6. A repeated start sets bits 13 and 6. A stop clears bits 14, 13, 6 and 5. Bits 12:11 are kept until reset or a general-call reset.
- R6: A stop while bit 14 is set sets bit 10. A stop while bit 14 is clear leaves bit 10 unchanged. `rd_stb_i` clears bit 10 on the next cycle; when a stop sets it in the same cycle, the set wins.
- R7: `irq_o` is high exactly while bit 10 is set and `cfg_stop_ie_i` is high.
- R8: A second byte is taken only after an accepted 0x00 address since the last start, repeated start or stop, and it sets bit 7. In bits 9:8 it writes: 0x06 gives 01; 0x04 gives 10; an odd byte whose bits [7:1] equal `cfg_alt_id_i` gives 11. Any other byte leaves bits 9:8 unchanged.
- R9: A second byte of 0x06 clears bits 14, 13, 12:11, 10, 6 and 5, and leaves bits 9:7 with their new values.
- R10: `gc_clr_i` clears bits 9:7. A taken second byte in the same cycle wins.
- R11: On `ack_slot_i`, bit 5 becomes `cfg_force_nack_i | txq_empty_i`. A start, repeated start or stop clears bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_start_i | input | 1 | Start condition pulse |
| evt_rstart_i | input | 1 | Repeated start pulse |
| evt_stop_i | input | 1 | Stop condition pulse |
| addr_vld_i | input | 1 | Address byte valid |
| addr_byte_i | input | 8 | Received address byte |
| gc2_vld_i | input | 1 | Second general-call byte valid |
| gc2_byte_i | input | 8 | Second general-call byte |
| ack_slot_i | input | 1 | Acknowledge slot of an outgoing byte |
| txq_empty_i | input | 1 | Transmit queue empty |
| cfg_ids_i | input | 28 | Four packed 7-bit target IDs |
| cfg_alt_id_i | input | 7 | Alternate ID for hardware general calls |
| cfg_gc_en_i | input | 1 | General-call enable |
| cfg_stop_ie_i | input | 1 | Stop interrupt enable |
| cfg_force_nack_i | input | 1 | Force NACK |
| gc_clr_i | input | 1 | Write-one clear of the general-call fields |
| rd_stb_i | input | 1 | Status read strobe |
| rd_data_o | output | 16 | Status word |
| irq_o | output | 1 | Stop interrupt, level |

## Verification
The bench programs two IDs to the same value. A priority encoder that picked the highest match would report index 3 instead of 1. It checks that a miss after a repeated start drops busy while keeping the addressed flag and the index; a design that cleared all three would lose the record of the first match. It checks that a general-call reset wipes every field except the sticky general-call code. It also drives read-with-stop and clear-with-second-byte in the same cycle, where a design with the wrong update order would lose a freshly set flag. Finally, it sends a second byte with no general call pending and an odd byte that does not equal the alternate ID. A design that skipped these guards would change the code.

// File: rtl/i2cs_trk_pkg.sv
package i2cs_trk_pkg;
  localparam int NUM_IDS = 4;
  localparam int ID_W    = 7;
  localparam int IDX_W   = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;
  localparam int STAT_W  = 16;

  localparam logic [7:0] GC2_RESET = 8'h06;
  localparam logic [7:0] GC2_PROG  = 8'h04;

  typedef enum logic [1:0] {
    GC_NONE     = 2'b00,
    GC_RST_PROG = 2'b01,
    GC_PROG     = 2'b10,
    GC_HW_ALT   = 2'b11
  } gc_code_e;

  // Field order MSB first gives the bit positions software decodes.
  typedef struct packed {
    logic             rsvd;     // 15
    logic             sel;      // 14
    logic             rstart;   // 13
    logic [IDX_W-1:0] idx;      // 12:11
    logic             stop_dn;  // 10
    gc_code_e         gc;       // 9:8
    logic             gc_seen;  // 7
    logic             busy;     // 6
    logic             nack;     // 5
    logic [4:0]       spare;    // 4:0
  } stat_t;
endpackage

// File: rtl/i2cs_rst_sync.sv
module i2cs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/i2cs_id_cmp.sv
module i2cs_id_cmp
  import i2cs_trk_pkg::*;
#(
  parameter int N  = NUM_IDS,
  parameter int W  = ID_W,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [7:0]     addr_byte_i,
  input  logic [N*W-1:0] ids_i,
  input  logic           gc_en_i,
  output logic           id_hit_o,
  output logic [IW-1:0]  idx_o,
  output logic           gc_hit_o,
  output logic           accept_o
);
  logic [W-1:0] key;
  logic [N-1:0] eq_v;
  logic         rsvd;
  logic         stbyte;

  assign key = addr_byte_i[7 -: W];

  genvar g;
  for (g = 0; g < N; g++) begin : g_cmp
    assign eq_v[g] = (ids_i[g*W +: W] == key);
  end

  // Lowest index wins.
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (eq_v[k]) idx_o = IW'(k);
    end
  end

  assign rsvd     = (key == '0);
  assign stbyte   = rsvd & addr_byte_i[0];
  assign gc_hit_o = rsvd & ~addr_byte_i[0] & gc_en_i;
  assign id_hit_o = (|eq_v) & ~rsvd;
  assign accept_o = id_hit_o | gc_hit_o | stbyte;
endmodule

// File: rtl/i2cs_gc_classify.sv
module i2cs_gc_classify
  import i2cs_trk_pkg::*;
#(
  parameter int W = ID_W
) (
  input  logic [7:0]   byte_i,
  input  logic [W-1:0] alt_id_i,
  output logic         upd_o,
  output gc_code_e     code_o,
  output logic         reset_o
);
  always_comb begin
    upd_o   = 1'b0;
    code_o  = GC_NONE;
    reset_o = 1'b0;
    if (byte_i == GC2_RESET) begin
      upd_o   = 1'b1;
      code_o  = GC_RST_PROG;
      reset_o = 1'b1;
    end else if (byte_i == GC2_PROG) begin
      upd_o  = 1'b1;
      code_o = GC_PROG;
    end else if (byte_i[0] && (byte_i[7 -: W] == alt_id_i)) begin
      upd_o  = 1'b1;
      code_o = GC_HW_ALT;
    end
  end
endmodule

// File: rtl/i2cs_status_trk.sv
module i2cs_status_trk
  import i2cs_trk_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt_start_i,
  input  logic                    evt_rstart_i,
  input  logic                    evt_stop_i,
  input  logic                    addr_vld_i,
  input  logic [7:0]              addr_byte_i,
  input  logic                    gc2_vld_i,
  input  logic [7:0]              gc2_byte_i,
  input  logic                    ack_slot_i,
  input  logic                    txq_empty_i,
  input  logic [NUM_IDS*ID_W-1:0] cfg_ids_i,
  input  logic [ID_W-1:0]         cfg_alt_id_i,
  input  logic                    cfg_gc_en_i,
  input  logic                    cfg_stop_ie_i,
  input  logic                    cfg_force_nack_i,
  input  logic                    gc_clr_i,
  input  logic                    rd_stb_i,
  output logic [STAT_W-1:0]       rd_data_o,
  output logic                    irq_o
);
  logic             rst_sync_n;
  logic             id_hit, gc_hit, accept;
  logic [IDX_W-1:0] hit_idx;
  logic             gc_upd, gc_rst;
  gc_code_e         gc_code;
  stat_t            stat_q, stat_n;
  logic             pend_q, pend_n;
  logic             upd_en;

  i2cs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  i2cs_id_cmp #(.N(NUM_IDS), .W(ID_W), .IW(IDX_W)) u_cmp (
    .addr_byte_i (addr_byte_i),
    .ids_i       (cfg_ids_i),
    .gc_en_i     (cfg_gc_en_i),
    .id_hit_o    (id_hit),
    .idx_o       (hit_idx),
    .gc_hit_o    (gc_hit),
    .accept_o    (accept)
  );

  i2cs_gc_classify #(.W(ID_W)) u_gc (
    .byte_i   (gc2_byte_i),
    .alt_id_i (cfg_alt_id_i),
    .upd_o    (gc_upd),
    .code_o   (gc_code),
    .reset_o  (gc_rst)
  );

  assign upd_en = evt_start_i | evt_rstart_i | evt_stop_i | addr_vld_i |
                  gc2_vld_i | ack_slot_i | gc_clr_i | rd_stb_i;

  // Later steps override earlier ones: clears first, stop last.
  always_comb begin
    stat_n = stat_q;
    pend_n = pend_q;
    if (rd_stb_i) stat_n.stop_dn = 1'b0;
    if (gc_clr_i) begin
      stat_n.gc      = GC_NONE;
      stat_n.gc_seen = 1'b0;
    end
    if (addr_vld_i) begin
      if (accept) stat_n.sel  = 1'b1;
      else        stat_n.busy = 1'b0;
      if (id_hit) stat_n.idx  = hit_idx;
      pend_n = gc_hit;
    end
    if (gc2_vld_i && pend_q) begin
      stat_n.gc_seen = 1'b1;
      pend_n         = 1'b0;
      if (gc_upd) stat_n.gc = gc_code;
      if (gc_rst) begin
        stat_n.sel     = 1'b0;
        stat_n.rstart  = 1'b0;
        stat_n.idx     = '0;
        stat_n.stop_dn = 1'b0;
        stat_n.busy    = 1'b0;
        stat_n.nack    = 1'b0;
      end
    end
    if (ack_slot_i) stat_n.nack = cfg_force_nack_i | txq_empty_i;
    if (evt_start_i || evt_rstart_i) begin
      stat_n.busy = 1'b1;
      stat_n.nack = 1'b0;
      pend_n      = 1'b0;
      if (evt_rstart_i) stat_n.rstart = 1'b1;
    end
    if (evt_stop_i) begin
      if (stat_q.sel) stat_n.stop_dn = 1'b1;
      stat_n.sel    = 1'b0;
      stat_n.rstart = 1'b0;
      stat_n.busy   = 1'b0;
      stat_n.nack   = 1'b0;
      pend_n        = 1'b0;
    end
    stat_n.rsvd  = 1'b0;
    stat_n.spare = '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stat_q <= '0;
      pend_q <= 1'b0;
    end else if (upd_en) begin
      stat_q <= stat_n;
      pend_q <= pend_n;
    end
  end

  assign rd_data_o = stat_q;
  assign irq_o     = stat_q.stop_dn & cfg_stop_ie_i;
endmodule

// File: rtl/i2cs_status_trk_chk.sv
module i2cs_status_trk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_start_i,
  input logic        evt_rstart_i,
  input logic        evt_stop_i,
  input logic        addr_vld_i,
  input logic        gc2_vld_i,
  input logic        ack_slot_i,
  input logic        cfg_force_nack_i,
  input logic        cfg_stop_ie_i,
  input logic        gc_clr_i,
  input logic        rd_stb_i,
  input logic [15:0] rd_data_o,
  input logic        irq_o
);
  p_stop_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop_i |=> !rd_data_o[14] && !rd_data_o[13] && !rd_data_o[6] && !rd_data_o[5]);

  p_rstart_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rstart_i && !evt_stop_i && !addr_vld_i && !gc2_vld_i |=> rd_data_o[13] && rd_data_o[6]);

  p_stop_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop_i && rd_data_o[14] |=> rd_data_o[10]);

  p_read_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i && !(evt_stop_i && rd_data_o[14]) |=> !rd_data_o[10]);

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_stop_ie_i && $rose(rd_data_o[10]) |-> irq_o);

  p_gc_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !gc_clr_i && !gc2_vld_i |=> $stable(rd_data_o[9:7]));

  p_force_nack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_slot_i && cfg_force_nack_i && !evt_start_i && !evt_rstart_i && !evt_stop_i
    |=> rd_data_o[5]);
endmodule

bind i2cs_status_trk i2cs_status_trk_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_sync_n),
  .evt_start_i      (evt_start_i),
  .evt_rstart_i     (evt_rstart_i),
  .evt_stop_i       (evt_stop_i),
  .addr_vld_i       (addr_vld_i),
  .gc2_vld_i        (gc2_vld_i),
  .ack_slot_i       (ack_slot_i),
  .cfg_force_nack_i (cfg_force_nack_i),
  .cfg_stop_ie_i    (cfg_stop_ie_i),
  .gc_clr_i         (gc_clr_i),
  .rd_stb_i         (rd_stb_i),
  .rd_data_o        (rd_data_o),
  .irq_o            (irq_o)
);

// File: tb/i2cs_status_trk_tb_top.sv
module i2cs_status_trk_tb_top;
  localparam logic [3:0] OP_START = 4'd0, OP_RSTART = 4'd1, OP_STOP = 4'd2,
                         OP_ADDR = 4'd3, OP_GC2 = 4'd4, OP_ACK0 = 4'd5,
                         OP_ACK1 = 4'd6, OP_READ = 4'd7, OP_GCCLR = 4'd8,
                         OP_STOPRD = 4'd9, OP_GC2CLR = 4'd10, OP_ACKF = 4'd11;
  localparam int NV = 34;
  // {op, data, expected status after the op}
  localparam logic [27:0] VEC [NV] = '{
    {OP_START,  8'h00, 16'h0040},  // R5
    {OP_ADDR,   8'h68, 16'h4840},  // R2 ids 1 and 3 equal, lowest wins
    {OP_ACK1,   8'h00, 16'h4860},  // R11
    {OP_ACK0,   8'h00, 16'h4840},  // R11
    {OP_RSTART, 8'h00, 16'h6840},  // R5
    {OP_ADDR,   8'hAD, 16'h7040},  // R2
    {OP_STOP,   8'h00, 16'h1400},  // R6
    {OP_READ,   8'h00, 16'h1000},  // R6
    {OP_START,  8'h00, 16'h1040},
    {OP_ADDR,   8'h7E, 16'h1000},  // R4
    {OP_STOP,   8'h00, 16'h1000},  // R6 no set when not addressed
    {OP_START,  8'h00, 16'h1040},
    {OP_ADDR,   8'h01, 16'h5040},  // R3 start byte
    {OP_STOP,   8'h00, 16'h1400},
    {OP_START,  8'h00, 16'h1440},
    {OP_ADDR,   8'h00, 16'h5440},  // R3 general call
    {OP_GC2,    8'h04, 16'h56C0},  // R8
    {OP_RSTART, 8'h00, 16'h76C0},
    {OP_ADDR,   8'h00, 16'h76C0},
    {OP_GC2,    8'h55, 16'h77C0},  // R8 alternate ID
    {OP_GCCLR,  8'h00, 16'h7440},  // R10
    {OP_STOP,   8'h00, 16'h1400},
    {OP_START,  8'h00, 16'h1440},
    {OP_ADDR,   8'h24, 16'h4440},
    {OP_ACK1,   8'h00, 16'h4460},
    {OP_RSTART, 8'h00, 16'h6440},
    {OP_ADDR,   8'h00, 16'h6440},
    {OP_GC2,    8'h06, 16'h0180},  // R9
    {OP_GC2,    8'h04, 16'h0180},  // R8 nothing pending
    {OP_READ,   8'h00, 16'h0180},
    {OP_START,  8'h00, 16'h01C0},
    {OP_ADDR,   8'h00, 16'h41C0},
    {OP_GC2,    8'h03, 16'h41C0},  // R8 odd byte, not alt
    {OP_STOP,   8'h00, 16'h0580}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_start_i, evt_rstart_i, evt_stop_i, addr_vld_i, gc2_vld_i;
  logic [7:0]  addr_byte_i, gc2_byte_i;
  logic        ack_slot_i, txq_empty_i, gc_clr_i, rd_stb_i;
  logic [27:0] cfg_ids_i;
  logic [6:0]  cfg_alt_id_i;
  logic        cfg_gc_en_i, cfg_stop_ie_i, cfg_force_nack_i;
  logic [15:0] rd_data_o;
  logic        irq_o;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 1'b0;

  always #4 clk = ~clk;

  i2cs_status_trk dut_i (
    .clk(clk), .rst_n(rst_n), .evt_start_i(evt_start_i), .evt_rstart_i(evt_rstart_i),
    .evt_stop_i(evt_stop_i), .addr_vld_i(addr_vld_i), .addr_byte_i(addr_byte_i),
    .gc2_vld_i(gc2_vld_i), .gc2_byte_i(gc2_byte_i), .ack_slot_i(ack_slot_i),
    .txq_empty_i(txq_empty_i), .cfg_ids_i(cfg_ids_i), .cfg_alt_id_i(cfg_alt_id_i),
    .cfg_gc_en_i(cfg_gc_en_i), .cfg_stop_ie_i(cfg_stop_ie_i),
    .cfg_force_nack_i(cfg_force_nack_i), .gc_clr_i(gc_clr_i), .rd_stb_i(rd_stb_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    {evt_start_i, evt_rstart_i, evt_stop_i, addr_vld_i, gc2_vld_i} = '0;
    {ack_slot_i, txq_empty_i, gc_clr_i, rd_stb_i, cfg_force_nack_i} = '0;
    addr_byte_i = '0;
    gc2_byte_i  = '0;
  endtask

  task automatic do_op(input logic [3:0] op, input logic [7:0] d);
    @(negedge clk);
    case (op)
      OP_START:   evt_start_i = 1'b1;
      OP_RSTART:  evt_rstart_i = 1'b1;
      OP_STOP:    evt_stop_i = 1'b1;
      OP_ADDR:    begin addr_vld_i = 1'b1; addr_byte_i = d; end
      OP_GC2:     begin gc2_vld_i = 1'b1; gc2_byte_i = d; end
      OP_ACK0:    ack_slot_i = 1'b1;
      OP_ACK1:    begin ack_slot_i = 1'b1; txq_empty_i = 1'b1; end
      OP_READ:    rd_stb_i = 1'b1;
      OP_GCCLR:   gc_clr_i = 1'b1;
      OP_STOPRD:  begin evt_stop_i = 1'b1; rd_stb_i = 1'b1; end
      OP_GC2CLR:  begin gc2_vld_i = 1'b1; gc2_byte_i = d; gc_clr_i = 1'b1; end
      OP_ACKF:    begin ack_slot_i = 1'b1; cfg_force_nack_i = 1'b1; end
      default:    ;
    endcase
    @(negedge clk);
    idle();
  endtask

  function automatic string op_req(input logic [3:0] op);
    case (op)
      OP_START, OP_RSTART:        return "R5";
      OP_STOP, OP_READ:           return "R6";
      OP_ADDR:                    return "R2";
      OP_GC2:                     return "R8";
      OP_ACK0, OP_ACK1:           return "R11";
      default:                    return "R10";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    idle();
    cfg_ids_i     = {7'h34, 7'h56, 7'h34, 7'h12};
    cfg_alt_id_i  = 7'h2A;
    cfg_gc_en_i   = 1'b1;
    cfg_stop_ie_i = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", rd_data_o, 16'h0000);
    chk("R1", {15'd0, irq_o}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][27:24], VEC[i][23:16]);
      chk(op_req(VEC[i][27:24]), rd_data_o, VEC[i][15:0]);
      chk("R7", {15'd0, irq_o}, {15'd0, VEC[i][10]});
    end

    // R7: interrupt follows the enable
    cfg_stop_ie_i = 1'b0; #1;
    chk("R7", {15'd0, irq_o}, 16'h0000);
    cfg_stop_ie_i = 1'b1; #1;
    chk("R7", {15'd0, irq_o}, 16'h0001);

    // R6: stop set wins over read clear
    do_op(OP_START, 8'h00);
    do_op(OP_ADDR, 8'h24);
    chk("R2", rd_data_o, 16'h45C0);
    do_op(OP_STOPRD, 8'h00);
    chk("R6", rd_data_o, 16'h0580);
    do_op(OP_READ, 8'h00);
    chk("R6", rd_data_o, 16'h0180);

    // R3: general call ignored when disabled
    cfg_gc_en_i = 1'b0;
    do_op(OP_START, 8'h00);
    do_op(OP_ADDR, 8'h00);
    chk("R3", rd_data_o, 16'h0180);
    cfg_gc_en_i = 1'b1;

    // R4: miss after repeated start keeps sel and index
    do_op(OP_START, 8'h00);
    do_op(OP_ADDR, 8'h68);
    do_op(OP_RSTART, 8'h00);
    chk("R5", rd_data_o, 16'h69C0);
    do_op(OP_ADDR, 8'hFE);
    chk("R4", rd_data_o, 16'h6980);

    // R11: forced NACK with data available
    do_op(OP_RSTART, 8'h00);
    do_op(OP_ADDR, 8'h68);
    do_op(OP_ACKF, 8'h00);
    chk("R11", rd_data_o, 16'h69E0);
    do_op(OP_ACK0, 8'h00);
    chk("R11", rd_data_o, 16'h69C0);

    // R10: second byte wins over same-cycle clear
    do_op(OP_RSTART, 8'h00);
    do_op(OP_ADDR, 8'h00);
    do_op(OP_GC2CLR, 8'h04);
    chk("R10", rd_data_o, 16'h6AC0);

    // R9: general-call reset keeps sticky fields only
    do_op(OP_RSTART, 8'h00);
    do_op(OP_ADDR, 8'h00);
    do_op(OP_GC2, 8'h06);
    chk("R9", rd_data_o, 16'h0180);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", rd_data_o, 16'h0000);
    chk("R1", {15'd0, irq_o}, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule